// File: doc/BRIEF.md
# Positional Popcount Engine

The engine counts, for each of the eight bit positions of a byte, how many bytes in a stream have that bit set. A job starts with a one-cycle start strobe that carries the total number of bytes. The bytes then arrive eight to a word over a valid/ready handshake. Every accepted word is treated as an 8x8 bit grid: lane i holds byte i, and the engine masks off the lanes past the end of the job. The grid is transposed so that each bit position becomes one byte, and each of those bytes is popcounted. The eight partial counts are added into eight independent accumulators.

Internally the work is a three-stage pipeline (load, transpose-and-popcount, accumulate) that takes one word per cycle with no stalls. A final short group is handled by zero-padding the unused lanes. All eight popcounts are still added, because the padded lanes add nothing. When the last partial count has been added, a one-cycle done pulse is raised. The counters then hold their values until the next start.

Top module: `pos_popcount_engine`

## Requirements
- R1: During reset and in the first cycle after it, `done` and `inReady` are low and every counter reads zero.
- R2: A start accepted while the engine is idle clears all eight counters and latches `totalCount`. In the next cycle the counters read zero, and `inReady` is high if the count is non-zero.
- R3: After a job, counter k (bits `[32k+31:32k]` of `bitCounts`) equals the number of consumed bytes that have bit k set. Byte i of a data word sits in bits `[8i+7:8i]`. In any busy cycle, no counter grows by more than 8.
- R4: A job of N bytes consumes exactly ceil(N/8) words. `inReady` is low once the last word has been accepted, and it is low whenever `done` is high.
- R5: In the final word of a job, with r = N mod 8 non-zero, the lanes with index r and above do not affect any counter, whatever data they carry.
- R6: A start with `totalCount` zero consumes no word, and it raises `done` in the very next cycle with all counters at zero.
- R7: `done` is a single-cycle pulse. It rises in the third cycle after the clock edge that accepted the last word of the job.
- R8: While idle and without a start, the counters do not change, even when `inValid` toggles with data.
- R9: A start asserted while a job is in progress is ignored, and the running job's result is unaffected.
- R10: While words remain to be consumed, `inReady` stays high in every cycle, so one word is taken per cycle when the source never pauses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a job when the engine is idle |
| totalCount | input | CNT_W | Number of bytes in the job, sampled with start |
| inData | input | 64 | Eight bytes, byte i in bits [8i+7:8i] |
| inValid | input | 1 | inData holds a word |
| inReady | output | 1 | Engine accepts a word this cycle |
| done | output | 1 | One-cycle pulse when the job's counts are final |
| bitCounts | output | 8*ACC_W | Eight per-bit-position counters, counter k in the k-th ACC_W slice |

## Verification
On every cycle the assertions check the following:
- a start from idle clears the counters, and a zero-length start completes at once;
- done lasts one cycle and always coincides with ready being low;
- the counters stay frozen while idle;
- no counter climbs faster than eight per cycle.

The exact per-position totals can only be shown by the bench's scenarios: short, exact-multiple and long jobs, garbage in the masked tail lanes, and all-ones words. The same holds for the word count per job, the three-cycle done latency, stall-free intake, and the immunity to a start issued mid-job.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  localparam int LANE_CNT   = 8;
  localparam int ELEM_W     = LANE_CNT;
  localparam int LANE_IDX_W = $clog2(LANE_CNT);
  localparam int WORD_W     = LANE_CNT * ELEM_W;
  localparam int POP_W      = LANE_IDX_W + 1;

  typedef logic [LANE_CNT-1:0][ELEM_W-1:0] grid_t;
  typedef logic [LANE_CNT-1:0][POP_W-1:0]  pop_vec_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } ctrl_state_e;

  typedef struct packed {
    logic             clearAcc;
    logic             loadGrid;
    logic             lastBlock;
    logic [POP_W-1:0] laneCount;
  } dp_strobe_t;

  function automatic logic [POP_W-1:0] popCount(input logic [ELEM_W-1:0] value);
    logic [POP_W-1:0] total;
    total = '0;
    for (int i = 0; i < ELEM_W; i++) begin
      total = total + POP_W'(value[i]);
    end
    return total;
  endfunction
endpackage

// File: rtl/ppc_ctrl.sv
module ppc_ctrl
  import ppc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] totalCount,
  input  logic             inValid,
  output logic             inReady,
  input  logic             lastAccum,
  output dp_strobe_t       strobes,
  output logic             done,
  output logic             busy
);
  localparam logic [CNT_W-1:0] BLOCK_SIZE = CNT_W'(LANE_CNT);

  ctrl_state_e      state;
  logic [CNT_W-1:0] remaining;
  logic             accept;
  logic             isLast;

  assign inReady = (state == ST_RUN);
  assign busy    = (state != ST_IDLE);
  assign accept  = inValid && inReady;
  assign isLast  = (remaining <= BLOCK_SIZE);

  always_comb begin
    strobes.clearAcc  = (state == ST_IDLE) && start;
    strobes.loadGrid  = accept;
    strobes.lastBlock = isLast;
    strobes.laneCount = isLast ? remaining[POP_W-1:0] : POP_W'(LANE_CNT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remaining <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (totalCount == '0) begin
              done <= 1'b1;
            end else begin
              remaining <= totalCount;
              state     <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (accept) begin
            if (isLast) begin
              state <= ST_DRAIN;
            end else begin
              remaining <= remaining - BLOCK_SIZE;
            end
          end
        end
        ST_DRAIN: begin
          if (lastAccum) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ppc_transpose.sv
module ppc_transpose
  import ppc_pkg::*;
(
  input  grid_t gridIn,
  output grid_t gridOut
);
  for (genvar bitPos = 0; bitPos < ELEM_W; bitPos++) begin : g_row
    for (genvar lane = 0; lane < LANE_CNT; lane++) begin : g_col
      assign gridOut[bitPos][lane] = gridIn[lane][bitPos];
    end
  end
endmodule

// File: rtl/ppc_datapath.sv
module ppc_datapath
  import ppc_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  dp_strobe_t                       strobes,
  input  logic [WORD_W-1:0]                inData,
  output logic                             lastAccum,
  output logic [LANE_CNT-1:0][ACC_W-1:0]   bitCounts
);
  grid_t    maskedGrid;
  grid_t    gridQ;
  grid_t    flipped;
  logic     gridValid;
  logic     gridLast;
  pop_vec_t popD;
  pop_vec_t popQ;
  logic     popValid;
  logic     popLast;

  for (genvar lane = 0; lane < LANE_CNT; lane++) begin : g_mask
    assign maskedGrid[lane] = (POP_W'(lane) < strobes.laneCount)
                              ? inData[lane*ELEM_W +: ELEM_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gridQ     <= '0;
      gridValid <= 1'b0;
      gridLast  <= 1'b0;
    end else begin
      gridValid <= strobes.loadGrid;
      if (strobes.loadGrid) begin
        gridQ    <= maskedGrid;
        gridLast <= strobes.lastBlock;
      end
    end
  end

  ppc_transpose u_flip (
    .gridIn  (gridQ),
    .gridOut (flipped)
  );

  for (genvar bitPos = 0; bitPos < LANE_CNT; bitPos++) begin : g_pop
    assign popD[bitPos] = popCount(flipped[bitPos]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      popQ     <= '0;
      popValid <= 1'b0;
      popLast  <= 1'b0;
    end else begin
      popValid <= gridValid;
      popLast  <= gridValid && gridLast;
      if (gridValid) begin
        popQ <= popD;
      end
    end
  end

  assign lastAccum = popValid && popLast;

  for (genvar bitPos = 0; bitPos < LANE_CNT; bitPos++) begin : g_acc
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bitCounts[bitPos] <= '0;
      end else if (strobes.clearAcc) begin
        bitCounts[bitPos] <= '0;
      end else if (popValid) begin
        bitCounts[bitPos] <= bitCounts[bitPos] + ACC_W'(popQ[bitPos]);
      end
    end
  end
endmodule

// File: rtl/pos_popcount_engine.sv
module pos_popcount_engine
  import ppc_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int CNT_W = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           start,
  input  logic [CNT_W-1:0]               totalCount,
  input  logic [WORD_W-1:0]              inData,
  input  logic                           inValid,
  output logic                           inReady,
  output logic                           done,
  output logic [LANE_CNT-1:0][ACC_W-1:0] bitCounts
);
  dp_strobe_t strobes;
  logic       lastAccum;
  logic       engineBusy;

  ppc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .totalCount (totalCount),
    .inValid    (inValid),
    .inReady    (inReady),
    .lastAccum  (lastAccum),
    .strobes    (strobes),
    .done       (done),
    .busy       (engineBusy)
  );

  ppc_datapath #(.ACC_W(ACC_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .inData    (inData),
    .lastAccum (lastAccum),
    .bitCounts (bitCounts)
  );
endmodule

// File: rtl/ppc_checker.sv
module ppc_checker
  import ppc_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int CNT_W = 32
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           start,
  input logic [CNT_W-1:0]               totalCount,
  input logic                           inReady,
  input logic                           done,
  input logic                           engineBusy,
  input logic [LANE_CNT-1:0][ACC_W-1:0] bitCounts
);
  assert_clear_on_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !engineBusy && totalCount != '0) |=> (bitCounts == '0 && inReady));

  assert_zero_job_R6: assert property (@(posedge clk) disable iff (!rstN)
    (start && !engineBusy && totalCount == '0) |=> (done && bitCounts == '0 && !inReady));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> !done);

  assert_idle_on_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!inReady && !engineBusy));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!engineBusy && !start) |=> $stable(bitCounts));

  for (genvar k = 0; k < LANE_CNT; k++) begin : g_step
    assert_lane_step_R3: assert property (@(posedge clk) disable iff (!rstN)
      engineBusy |=> ((bitCounts[k] - $past(bitCounts[k])) <= ACC_W'(LANE_CNT)));
  end
endmodule

bind pos_popcount_engine ppc_checker #(.ACC_W(ACC_W), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .totalCount (totalCount),
  .inReady    (inReady),
  .done       (done),
  .engineBusy (engineBusy),
  .bitCounts  (bitCounts)
);

// File: tb/pos_popcount_engine_tb_top.sv
module pos_popcount_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ACC_W = 32;
  localparam int CNT_W = 32;
  localparam int JOBS = 8;

  localparam int          JOB_N      [JOBS] = '{1, 7, 8, 9, 16, 37, 64, 203};
  localparam logic [63:0] JOB_SEED   [JOBS] = '{64'd3, 64'd5, 64'd0, 64'd11, 64'd13, 64'd17, 64'd0, 64'd21};
  localparam bit          JOB_BUBBLE [JOBS] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  typedef logic [7:0][ACC_W-1:0] counts_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] totalCount = '0;
  logic [63:0]      inData = '0;
  logic             inValid = 1'b0;
  logic             inReady;
  logic             done;
  counts_t          bitCounts;

  int  checks = 0;
  int  fails = 0;
  bit  finished = 1'b0;

  pos_popcount_engine #(.ACC_W(ACC_W), .CNT_W(CNT_W)) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .totalCount (totalCount),
    .inData     (inData),
    .inValid    (inValid),
    .inReady    (inReady),
    .done       (done),
    .bitCounts  (bitCounts)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic logic [63:0] genWord(input logic [63:0] seed, input int idx);
    logic [63:0] w;
    if (seed == 64'd0) return '1;
    w = seed * 64'h9E3779B97F4A7C15 + 64'(idx) * 64'hC2B2AE3D27D4EB4F;
    w = w ^ (w >> 31);
    w = w * 64'h94D049BB133111EB;
    w = w ^ (w >> 29);
    return w;
  endfunction

  task automatic runJob(input int n, input logic [63:0] seed, input bit bubbles,
                        input int busyStartAt);
    counts_t expCounts = '0;
    counts_t heldCounts;
    int nWords = (n + 7) / 8;
    int idx = 0;
    int cyc = 0;
    int doneCyc = -1;
    int lastAcc = -1;
    int stalls = 0;
    bit extraReady = 1'b0;
    bit give;
    bit heldOk = 1'b1;

    for (int w = 0; w < nWords; w++) begin
      logic [63:0] word = genWord(seed, w);
      int lanes = (n - 8*w) < 8 ? (n - 8*w) : 8;
      for (int l = 0; l < lanes; l++)
        for (int b = 0; b < 8; b++)
          expCounts[b] = expCounts[b] + ACC_W'(word[8*l + b]);
    end

    @(negedge clk);
    start = 1'b1;
    totalCount = CNT_W'(n);
    inValid = 1'b0;

    while (doneCyc < 0 && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      start = (cyc == busyStartAt);
      totalCount = start ? CNT_W'(3) : CNT_W'(n);
      if (done) doneCyc = cyc;
      if (cyc == 1 && n != 0)
        check(bitCounts == '0 && inReady,
              $sformatf("R2 n=%0d after start counts=%h ready=%0b exp counts=0 ready=1",
                        n, bitCounts, inReady));
      give = (idx < nWords) && !(bubbles && (cyc % 3 == 0));
      inValid = give;
      inData = give ? genWord(seed, idx) : 64'hA5A5_5A5A_FFFF_0000;
      if (idx > 0 && idx < nWords && !inReady) stalls++;
      if (idx >= nWords && inReady) extraReady = 1'b1;
      if (give && inReady) begin
        idx++;
        lastAcc = cyc;
      end
    end
    inValid = 1'b0;
    start = 1'b0;

    check(doneCyc > 0, $sformatf("R7 n=%0d done seen=%0b exp 1", n, doneCyc > 0));
    check(idx == nWords && !extraReady,
          $sformatf("R4 n=%0d words=%0d extraReady=%0b exp words=%0d extraReady=0",
                    n, idx, extraReady, nWords));
    if (n == 0)
      check(doneCyc == 1, $sformatf("R6 zero job done cycle=%0d exp 1", doneCyc));
    else
      check(doneCyc - lastAcc == 3,
            $sformatf("R7 n=%0d done latency=%0d exp 3", n, doneCyc - lastAcc));
    if (!bubbles && n != 0)
      check(stalls == 0, $sformatf("R10 n=%0d stall cycles=%0d exp 0", n, stalls));
    check(bitCounts == expCounts,
          $sformatf("R3 R5 R9 n=%0d counts=%h exp %h", n, bitCounts, expCounts));

    @(negedge clk);
    check(!done, $sformatf("R7 n=%0d done width: done=%0b exp 0", n, done));

    heldCounts = bitCounts;
    for (int i = 0; i < 4; i++) begin
      inValid = 1'b1;
      inData = genWord(64'd99, i);
      @(negedge clk);
      if (bitCounts != heldCounts || inReady) heldOk = 1'b0;
    end
    inValid = 1'b0;
    check(heldOk, $sformatf("R8 n=%0d counts=%h exp %h", n, bitCounts, heldCounts));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !inReady && bitCounts == '0,
          $sformatf("R1 in reset done=%0b ready=%0b counts=%h exp 0 0 0", done, inReady, bitCounts));
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !inReady && bitCounts == '0,
          $sformatf("R1 after reset done=%0b ready=%0b counts=%h exp 0 0 0", done, inReady, bitCounts));

    for (int j = 0; j < JOBS; j++) begin
      runJob(JOB_N[j], JOB_SEED[j], JOB_BUBBLE[j], 0);
    end

    // R6: zero-length job after a non-empty one clears the counts
    runJob(0, 64'd7, 1'b0, 0);
    check(bitCounts == '0, $sformatf("R6 counts=%h exp 0", bitCounts));

    // R9: start mid-job with a different count is ignored
    runJob(20, 64'd31, 1'b0, 3);
    // R9: start during the drain phase is ignored as well
    runJob(12, 64'd41, 1'b0, 4);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired, run hung");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule